// File: doc/BRIEF.md
# LCD Panel Raster Timing Generator

This block produces the raster timing for a TFT LCD panel: horizontal sync, vertical sync, a data-enable strobe and the pixel coordinates of the current position, together with a 24-bit RGB value for that pixel. It advances one position per pixel-enable strobe, so the surrounding logic chooses the pixel rate. In normal operation it forwards RGB from an external pixel source. When that source has nothing valid, it drives a programmable background colour. It can also produce a coordinate test pattern or eight vertical colour bars without any source.

Software programs the geometry, sync polarities, operating mode and background colour through a small register write port. Each write lands in a shadow register set. The timing keeps using its live set until an update has been requested and the raster reaches the end of the active frame. At that point every shadow value moves into the live set in one step, so a frame is never shown with a mix of old and new settings.

Top module: `lcd_raster_timer`

## Requirements
- R1: After reset every shadow and live field is zero and the mode is off. hsync, vsync, de and rgb are then all 0.
- R2: Each line is made of the active pixels, then the front porch, then the sync pulse, then the back porch. The positions are counted by pix_x from 0. Register address 0 holds the front porch in bits 10:0, the sync width in bits 21:11 and the back porch in bits 31:22. The raw hsync is high only inside the sync pulse, and it keeps running on every line, including the vertical blanking lines.
- R3: A frame runs in whole lines in the same order: active, front porch, sync, back porch. The line count is given by pix_y. Register address 1 uses the same field layout as address 0, in lines. The raw vsync is high only on the lines of the sync pulse.
- R4: Register address 2 sets the active width in bits 7:0, in units of 16 pixels, and the active height in lines in bits 26:16.
- R5: Register address 3 controls sync polarity. When bit 0 is set the hsync output is inverted, and when bit 1 is set the vsync output is inverted.
- R6: de is 1 exactly when pix_x is below the active width, pix_y is below the active height and the mode is not off.
- R7: Register address 4 bits 1:0 select the mode: 0 off, 1 normal, 2 test, 3 bars. In normal mode with de high, rgb equals src_rgb when src_valid is 1. Otherwise it equals the background colour at address 5: red in bits 23:16, green in 15:8, blue in 7:0. Whenever de is low, rgb is 0.
- R8: In bars mode the active width is split into eight equal bars. Bar number pix_x / (2 × width units) is shown in this order: white, yellow, cyan, green, magenta, red, blue, black.
- R9: In test mode with de high, rgb is {pix_x[7:0], pix_y[7:0], pix_x[7:0] ^ pix_y[7:0]}.
- R10: In off mode the counters keep running, but hsync and vsync stay at their inactive levels (the polarity bit), and de and rgb are 0.
- R11: Writes to addresses 0 to 5 change only the shadow set and have no visible effect until a commit. Writing address 6 with bit 30 set raises a pending update request. Writing address 6 with bit 30 clear, or writing address 7, has no effect.
- R12: A pending request commits on the pixel strobe that ends the last active line. If the live height is zero, it commits on the next pixel strobe instead. At the commit the whole shadow set is copied into the live set and the request clears. The position restarts at pix_x 0, pix_y equal to the new height. If a write arrives on the commit cycle, the copy takes the shadow values from before that write, and an update request written on that cycle stays pending.
- R13: While pix_en is low, the position and every output that depends on it hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en | input | 1 | Pixel strobe; the position advances once per strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| src_valid | input | 1 | The external pixel source has valid data |
| src_rgb | input | 24 | External pixel colour |
| hsync | output | 1 | Horizontal sync, after the polarity setting |
| vsync | output | 1 | Vertical sync, after the polarity setting |
| de | output | 1 | Data enable for the active window |
| pix_x | output | CNT_W (14) | Pixel position within the line |
| pix_y | output | CNT_W (14) | Line position within the frame |
| rgb | output | 24 | Output pixel colour |

## Verification
The commit and a configuration write can fall on the same clock edge. There are two cases: a shadow write landing on the strobe that ends the last active line, and a new update request landing there. The bench follows the raster position in its own model, predicts the exact commit strobe and issues the write on that cycle. It then judges the result by comparing every output over the following frames. Those frames must show the pre-write shadow in force and, for the request case, a second commit one frame later.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

   localparam int CFG_W  = 32;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_HTIM = 3'd0;
   localparam logic [ADDR_W-1:0] A_VTIM = 3'd1;
   localparam logic [ADDR_W-1:0] A_SIZE = 3'd2;
   localparam logic [ADDR_W-1:0] A_POL  = 3'd3;
   localparam logic [ADDR_W-1:0] A_MODE = 3'd4;
   localparam logic [ADDR_W-1:0] A_BG   = 3'd5;
   localparam logic [ADDR_W-1:0] A_UPD  = 3'd6;

   localparam int FP_LSB      = 0;
   localparam int PW_LSB      = 11;
   localparam int BP_LSB      = 22;
   localparam int HGT_LSB     = 16;
   localparam int UPD_REQ_BIT = 30;

   typedef enum logic [1:0] {
      MODE_OFF    = 2'd0,
      MODE_NORMAL = 2'd1,
      MODE_TEST   = 2'd2,
      MODE_BARS   = 2'd3
   } lcd_mode_e;

   // bar 0..7 : white, yellow, cyan, green, magenta, red, blue, black
   function automatic logic [23:0] bar_colour(input logic [2:0] idx);
      return {{8{~idx[1]}}, {8{~idx[2]}}, {8{~idx[0]}}};
   endfunction

endpackage

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
   import lcd_timing_pkg::*;
#(
   parameter int FIELD_W = 11,
   parameter int UNIT_W  = 8
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [CFG_W-1:0]   wdata,
   input  logic               commit,
   output logic               req,
   output logic [FIELD_W-1:0] h_fp,
   output logic [FIELD_W-1:0] h_pw,
   output logic [FIELD_W-1:0] h_bp,
   output logic [FIELD_W-1:0] v_fp,
   output logic [FIELD_W-1:0] v_pw,
   output logic [FIELD_W-1:0] v_bp,
   output logic [FIELD_W-1:0] height,
   output logic [FIELD_W-1:0] nxt_height,
   output logic [UNIT_W-1:0]  units,
   output logic [1:0]         pol,
   output lcd_mode_e          mode,
   output logic [23:0]        bg
);

   typedef struct packed {
      logic [FIELD_W-1:0] hfp;
      logic [FIELD_W-1:0] hpw;
      logic [FIELD_W-1:0] hbp;
      logic [FIELD_W-1:0] vfp;
      logic [FIELD_W-1:0] vpw;
      logic [FIELD_W-1:0] vbp;
      logic [FIELD_W-1:0] hgt;
      logic [UNIT_W-1:0]  units;
      logic [1:0]         pol;
      lcd_mode_e          mode;
      logic [23:0]        bg;
   } cfg_t;

   cfg_t shadow_q, live_q;
   logic req_q;
   logic unused_wbits;

   assign unused_wbits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         live_q   <= '0;
         req_q    <= 1'b0;
      end else begin
         if (commit) begin
            live_q <= shadow_q;
            req_q  <= 1'b0;
         end
         if (we) begin
            case (addr)
               A_HTIM: begin
                  shadow_q.hfp <= wdata[FP_LSB +: FIELD_W];
                  shadow_q.hpw <= wdata[PW_LSB +: FIELD_W];
                  shadow_q.hbp <= FIELD_W'(wdata >> BP_LSB);
               end
               A_VTIM: begin
                  shadow_q.vfp <= wdata[FP_LSB +: FIELD_W];
                  shadow_q.vpw <= wdata[PW_LSB +: FIELD_W];
                  shadow_q.vbp <= FIELD_W'(wdata >> BP_LSB);
               end
               A_SIZE: begin
                  shadow_q.units <= wdata[UNIT_W-1:0];
                  shadow_q.hgt   <= wdata[HGT_LSB +: FIELD_W];
               end
               A_POL:  shadow_q.pol  <= wdata[1:0];
               A_MODE: shadow_q.mode <= lcd_mode_e'(wdata[1:0]);
               A_BG:   shadow_q.bg   <= wdata[23:0];
               A_UPD:  if (wdata[UPD_REQ_BIT]) req_q <= 1'b1;
               default: ;
            endcase
         end
      end
   end

   assign req        = req_q;
   assign h_fp       = live_q.hfp;
   assign h_pw       = live_q.hpw;
   assign h_bp       = live_q.hbp;
   assign v_fp       = live_q.vfp;
   assign v_pw       = live_q.vpw;
   assign v_bp       = live_q.vbp;
   assign height     = live_q.hgt;
   assign nxt_height = shadow_q.hgt;
   assign units      = live_q.units;
   assign pol        = live_q.pol;
   assign mode       = live_q.mode;
   assign bg         = live_q.bg;

   // R12: a request only drops through a commit
   assert_req_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_q) |-> $past(commit));

   // R12: the live set after a commit is the shadow from before that edge
   assert_copy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> live_q == $past(shadow_q));

endmodule

// File: rtl/lcd_axis_region.sv
module lcd_axis_region #(
   parameter int CNT_W = 14
)(
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] act,
   input  logic [CNT_W-1:0] fp,
   input  logic [CNT_W-1:0] pw,
   input  logic [CNT_W-1:0] bp,
   output logic             in_act,
   output logic             in_sync,
   output logic             last
);

   logic [CNT_W-1:0] sync_lo, sync_hi, total;

   assign sync_lo = act + fp;
   assign sync_hi = sync_lo + pw;
   assign total   = sync_hi + bp;

   assign in_act  = cnt < act;
   assign in_sync = (cnt >= sync_lo) && (cnt < sync_hi);
   assign last    = ({1'b0, cnt} + 1'b1) >= {1'b0, total};

endmodule

// File: rtl/lcd_pixel_mux.sv
module lcd_pixel_mux
   import lcd_timing_pkg::*;
#(
   parameter int UNIT_W = 8,
   parameter int CNT_W  = 14
)(
   input  lcd_mode_e         mode,
   input  logic              de,
   input  logic              src_valid,
   input  logic [23:0]       src_rgb,
   input  logic [23:0]       bg,
   input  logic [UNIT_W-1:0] units,
   input  logic [CNT_W-1:0]  h,
   input  logic [CNT_W-1:0]  v,
   output logic [23:0]       rgb
);

   localparam int NBARS = 8;

   logic [NBARS-2:0] past_edge;
   logic [2:0]       bar_idx;
   logic [7:0]       hx, vy;

   // each bar is 2*units pixels wide; one comparator per inner boundary
   generate
      for (genvar k = 1; k < NBARS; k++) begin : g_bar
         assign past_edge[k-1] = h >= (CNT_W'(units) * CNT_W'(2 * k));
      end
   endgenerate

   assign bar_idx = 3'($countones(past_edge));
   assign hx      = 8'(h);
   assign vy      = 8'(v);

   always_comb begin
      rgb = '0;
      if (de) begin
         case (mode)
            MODE_NORMAL: rgb = src_valid ? src_rgb : bg;
            MODE_TEST:   rgb = {hx, vy, hx ^ vy};
            MODE_BARS:   rgb = bar_colour(bar_idx);
            default:     rgb = '0;
         endcase
      end
   end

endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
   import lcd_timing_pkg::*;
#(
   parameter  int FIELD_W = 11,
   parameter  int UNIT_W  = 8,
   localparam int CNT_W   = (((UNIT_W + 4) > FIELD_W) ? (UNIT_W + 4) : FIELD_W) + 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_en,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              src_valid,
   input  logic [23:0]       src_rgb,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic [CNT_W-1:0]  pix_x,
   output logic [CNT_W-1:0]  pix_y,
   output logic [23:0]       rgb
);

   generate
      if (FIELD_W < 4 || FIELD_W > PW_LSB) begin : g_bad_field
         $error("FIELD_W must lie in 4..11");
      end
      if (UNIT_W < 1 || UNIT_W > HGT_LSB) begin : g_bad_unit
         $error("UNIT_W must lie in 1..16");
      end
   endgenerate

   logic               req, commit;
   logic [FIELD_W-1:0] h_fp, h_pw, h_bp, v_fp, v_pw, v_bp, height, nxt_height;
   logic [UNIT_W-1:0]  units;
   logic [1:0]         pol;
   lcd_mode_e          mode;
   logic [23:0]        bg;

   logic [CNT_W-1:0]   h_cnt, v_cnt, h_act, v_act;
   logic               h_in_act, hs_raw, h_last;
   logic               v_in_act, vs_raw, v_last;

   lcd_cfg_regs #(.FIELD_W(FIELD_W), .UNIT_W(UNIT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .commit(commit), .req(req),
      .h_fp(h_fp), .h_pw(h_pw), .h_bp(h_bp),
      .v_fp(v_fp), .v_pw(v_pw), .v_bp(v_bp),
      .height(height), .nxt_height(nxt_height),
      .units(units), .pol(pol), .mode(mode), .bg(bg)
   );

   assign h_act = CNT_W'({units, 4'b0000});
   assign v_act = CNT_W'(height);

   lcd_axis_region #(.CNT_W(CNT_W)) u_hreg (
      .cnt(h_cnt), .act(h_act),
      .fp(CNT_W'(h_fp)), .pw(CNT_W'(h_pw)), .bp(CNT_W'(h_bp)),
      .in_act(h_in_act), .in_sync(hs_raw), .last(h_last)
   );

   lcd_axis_region #(.CNT_W(CNT_W)) u_vreg (
      .cnt(v_cnt), .act(v_act),
      .fp(CNT_W'(v_fp)), .pw(CNT_W'(v_pw)), .bp(CNT_W'(v_bp)),
      .in_act(v_in_act), .in_sync(vs_raw), .last(v_last)
   );

   // frame end = strobe closing the last active line (any strobe if height is 0)
   assign commit = req && pix_en &&
                   ((v_act == '0) || (h_last && ((v_cnt + 1'b1) == v_act)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_cnt <= '0;
         v_cnt <= '0;
      end else if (commit) begin
         h_cnt <= '0;
         v_cnt <= CNT_W'(nxt_height);
      end else if (pix_en) begin
         if (h_last) begin
            h_cnt <= '0;
            v_cnt <= v_last ? '0 : v_cnt + 1'b1;
         end else begin
            h_cnt <= h_cnt + 1'b1;
         end
      end
   end

   assign hsync = (mode == MODE_OFF) ? pol[0] : (hs_raw ^ pol[0]);
   assign vsync = (mode == MODE_OFF) ? pol[1] : (vs_raw ^ pol[1]);
   assign de    = (mode != MODE_OFF) && h_in_act && v_in_act;
   assign pix_x = h_cnt;
   assign pix_y = v_cnt;

   lcd_pixel_mux #(.UNIT_W(UNIT_W), .CNT_W(CNT_W)) u_mux (
      .mode(mode), .de(de), .src_valid(src_valid), .src_rgb(src_rgb),
      .bg(bg), .units(units), .h(h_cnt), .v(v_cnt), .rgb(rgb)
   );

   // R13: no strobe, no movement
   assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> $stable(h_cnt) && $stable(v_cnt));

   // R3: vertical sync starts only at the start of a line
   assert_vs_line_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vs_raw) |-> h_cnt == '0);

   // R6: the active window never overlaps a sync pulse
   assert_de_no_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> !hs_raw && !vs_raw);

endmodule

// File: tb/lcd_raster_timer_tb.sv
module lcd_raster_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_en = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        src_valid = 1'b0;
   logic [23:0] src_rgb = '0;
   logic        hsync, vsync, de;
   logic [13:0] pix_x, pix_y;
   logic [23:0] rgb;

   always #5 clk = ~clk;

   lcd_raster_timer u_dut (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .src_valid(src_valid),
      .src_rgb(src_rgb), .hsync(hsync), .vsync(vsync), .de(de),
      .pix_x(pix_x), .pix_y(pix_y), .rgb(rgb)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    cmp_on = 1'b0;
   bit    done = 1'b0;
   bit    pen_rand = 1'b0;
   string ph = "R1";
   logic [15:0] lfsr = 16'hACE1;

   // ---------------- reference model ----------------
   int sh[6];
   int lv[6];
   bit mreq;
   int mh, mv;

   function automatic int fld(input int w, input int lsb);
      return (w >>> lsb) & 32'h7FF;
   endfunction
   function automatic int m_hact(); return (lv[2] & 32'hFF) * 16; endfunction
   function automatic int m_vact(); return fld(lv[2], 16); endfunction
   function automatic int m_htot();
      return m_hact() + fld(lv[0], 0) + fld(lv[0], 11) + fld(lv[0], 22);
   endfunction
   function automatic int m_vtot();
      return m_vact() + fld(lv[1], 0) + fld(lv[1], 11) + fld(lv[1], 22);
   endfunction
   function automatic bit m_commit(input bit pen);
      return mreq && pen && (m_vact() == 0 ||
             (mh + 1 >= m_htot() && mv + 1 == m_vact()));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (sh[i]) begin sh[i] = 0; lv[i] = 0; end
         mreq = 1'b0; mh = 0; mv = 0;
      end else begin
         if (m_commit(pix_en)) begin
            mv = fld(sh[2], 16);
            mh = 0;
            foreach (sh[i]) lv[i] = sh[i];
            mreq = 1'b0;
         end else if (pix_en) begin
            if (mh + 1 >= m_htot()) begin
               mh = 0;
               if (mv + 1 >= m_vtot()) mv = 0; else mv = mv + 1;
            end else begin
               mh = mh + 1;
            end
         end
         if (cfg_we) begin
            if (cfg_addr < 3'd6) sh[cfg_addr] = cfg_wdata;
            else if (cfg_addr == 3'd6 && cfg_wdata[30]) mreq = 1'b1;
         end
      end
   end

   task automatic cmp(input string sig, input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s (phase %s) %s at t=%0t: actual=%0h expected=%0h",
                  tag, ph, sig, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         int mode, hact, vact, hsl, hsh, vsl, vsh, p0, p1, e_rgb, idx, u;
         bit hsr, vsr, e_de;
         string rtag;
         mode = lv[4] & 3; hact = m_hact(); vact = m_vact();
         hsl = hact + fld(lv[0], 0); hsh = hsl + fld(lv[0], 11);
         vsl = vact + fld(lv[1], 0); vsh = vsl + fld(lv[1], 11);
         p0 = lv[3] & 1; p1 = (lv[3] >> 1) & 1;
         hsr = (mh >= hsl) && (mh < hsh);
         vsr = (mv >= vsl) && (mv < vsh);
         e_de = (mode != 0) && (mh < hact) && (mv < vact);
         u = lv[2] & 32'hFF;
         e_rgb = 0;
         if (e_de) begin
            case (mode)
               1: e_rgb = src_valid ? int'(src_rgb) : (lv[5] & 32'hFFFFFF);
               2: e_rgb = ((mh & 255) << 16) | ((mv & 255) << 8) | ((mh ^ mv) & 255);
               default: begin
                  idx = mh / (2 * u);
                  if (idx > 7) idx = 7;
                  case (idx)
                     0: e_rgb = 24'hFFFFFF;
                     1: e_rgb = 24'hFFFF00;
                     2: e_rgb = 24'h00FFFF;
                     3: e_rgb = 24'h00FF00;
                     4: e_rgb = 24'hFF00FF;
                     5: e_rgb = 24'hFF0000;
                     6: e_rgb = 24'h0000FF;
                     default: e_rgb = 24'h000000;
                  endcase
               end
            endcase
         end
         rtag = (mode == 1) ? "R7" : (mode == 2) ? "R9" : (mode == 3) ? "R8" : "R10";
         cmp("hsync", "R2", int'(hsync), (mode == 0) ? p0 : (int'(hsr) ^ p0));
         cmp("vsync", "R3", int'(vsync), (mode == 0) ? p1 : (int'(vsr) ^ p1));
         cmp("de", "R6", int'(de), int'(e_de));
         cmp("pix_x", "R6", int'(pix_x), mh);
         cmp("pix_y", "R6", int'(pix_y), mv);
         cmp("rgb", rtag, int'(rgb), e_rgb);
      end
   end

   // ---------------- stimulus ----------------
   task automatic drive(input bit we_i, input int a, input int d);
      @(posedge clk); #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pix_en    = pen_rand ? lfsr[0] : 1'b1;
      src_valid = lfsr[3];
      src_rgb   = {lfsr[7:0], lfsr[15:8], lfsr[11:4]};
      cfg_we    = we_i;
      cfg_addr  = 3'(a);
      cfg_wdata = d;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 0, 0);
   endtask

   task automatic wr(input int a, input int d);
      drive(1'b1, a, d);
   endtask

   function automatic int tim(input int fp, input int pw, input int bp);
      return (bp << 22) | (pw << 11) | fp;
   endfunction

   // hold pix_en high until the model predicts a commit, then write on that edge
   task automatic write_on_commit(input int a, input int d);
      for (int i = 0; i < 2000; i++) begin
         @(posedge clk); #2;
         pix_en = 1'b1;
         cfg_we = 1'b0;
         if (m_commit(1'b1)) begin
            cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
            break;
         end
      end
   endtask

   task automatic directed(input string tag, input bit ok, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s directed: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   int de_seen;
   always @(negedge clk) if (de) de_seen++;

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired (phase %s)", ph);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset outputs
      directed("R1", {hsync, vsync, de} == 3'b000 && rgb == 24'h0, int'({hsync, vsync, de}), 0);
      @(posedge clk); #2; rst_n = 1'b1;
      cmp_on = 1'b1;
      run(20);

      // R2 R3 R4 R7: normal mode with a small panel (16 x 4 active)
      ph = "R4";
      wr(0, tim(2, 3, 4));
      wr(1, tim(1, 2, 1));
      wr(2, (4 << 16) | 1);
      wr(5, 32'h123456);
      wr(4, 1);
      wr(6, 32'h4000_0000);
      run(520);

      // R13: irregular pixel strobe
      ph = "R13";
      pen_rand = 1'b1;
      run(400);
      pen_rand = 1'b0;

      // R5: both polarities inverted
      ph = "R5";
      wr(3, 3);
      wr(6, 32'h4000_0000);
      run(420);

      // R8: colour bars over 32 active pixels
      ph = "R8";
      wr(3, 0);
      wr(2, (3 << 16) | 2);
      wr(4, 3);
      wr(6, 32'h4000_0000);
      run(650);

      // R9: test pattern
      ph = "R9";
      wr(4, 2);
      wr(6, 32'h4000_0000);
      run(400);

      // R11: shadow writes without a valid request stay invisible
      ph = "R11";
      wr(4, 0);
      wr(5, 32'hABCDEF);
      run(300);
      wr(6, 32'h0000_0001);
      wr(7, 32'h4000_0000);
      de_seen = 0;
      run(300);
      directed("R11", de_seen > 0, de_seen, 1);

      // R12: shadow write on the commit edge; copy uses the older shadow
      ph = "R12";
      wr(4, 1);
      wr(6, 32'h4000_0000);
      write_on_commit(4, 3);
      de_seen = 0;
      run(300);
      directed("R12", de_seen > 0, de_seen, 1);
      // R12: a request written on the commit edge stays pending
      wr(5, 32'h00FF00);
      wr(6, 32'h4000_0000);
      write_on_commit(6, 32'h4000_0000);
      run(10);
      wr(4, 2);
      run(700);

      // R10: off mode
      ph = "R10";
      wr(3, 2);
      wr(4, 0);
      wr(6, 32'h4000_0000);
      run(350);
      de_seen = 0;
      run(300);
      directed("R10", de_seen == 0, de_seen, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule